// File: doc/BRIEF.md
# Palette and Register Write Port

This block is the write front end of a video controller. Software talks to it with one 32-bit word per write: the top eight bits name the target register and the low 24 bits carry the value. Colour lookup entries are not addressed directly. A pointer-reset write zeroes an internal pointer. Each following colour-data write stores its value in a 256-entry colour RAM at that pointer and then moves the pointer on by one, wrapping from the last entry back to the first.

All other known registers are held in a shadow register file. These are the border colour, three cursor colours, eight horizontal and eight vertical timing values, and the external, clock-synthesiser, control and data-control words. A write to an unassigned register code is refused: an error strobe is raised and no state changes.

A separate read-back port returns either a shadow register or a colour entry, one cycle after the index is presented. This lets software recover the controller's full programmed state.

Top module: `vctl_regport`

## Requirements
- R1: The register code is taken from `wr_word[31:24]` and the value from `wr_word[23:0]`. A write takes effect at the rising clock edge where `wr_en` is high.
- R2: Code 0x01 (pointer reset) sets the colour pointer to 0 whatever its value bits hold. It changes no colour entry and no shadow register.
- R3: Code 0x00 (colour data) stores the value in colour entry [pointer]. The pointer then advances by one, so consecutive data writes fill consecutive entries.
- R4: The colour pointer is 8 bits wide. A data write at entry 255 leaves the pointer at 0, so the 257th write after a pointer reset overwrites entry 0.
- R5: Codes 0x40+n, for n from 0 to 23, write shadow register n. The shadow order is: border colour; cursor colours 1 to 3; horizontal cycle, sync width, border start, display start, display end, border end, cursor start and interlace; vertical cycle, sync width, border start, display start, display end, border end, cursor start and cursor end; external; clock synthesiser; control; data control.
- R6: Any other code (0x02 to 0x3F, 0x58 to 0xFF) with `wr_en` high drives `wr_err` high in that same cycle, combinationally. Such a write changes no shadow register, no colour entry and not the pointer. `wr_err` is low whenever no refused write is presented.
- R7: Read-back uses `rd_space`: 0 selects shadow register `rd_idx`, 1 selects colour entry `rd_idx`. The result is on `rd_data` after the next rising edge and holds until the following edge. A shadow index of 24 or more reads as 0.
- R8: While `rst_n` is low, the pointer and all shadow registers are cleared and `rd_data` reads 0.
- R9: A read presented in the same cycle as a write to the same location returns the content held before that write.
- R10: With `wr_en` low, nothing changes, whatever `wr_word` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_word | input | 32 | Register code [31:24] merged with value [23:0] |
| wr_err | output | 1 | High while a write with an unassigned code is presented |
| rd_space | input | 1 | Read-back space: 0 shadow, 1 colour RAM |
| rd_idx | input | 8 | Read-back index |
| rd_data | output | 24 | Read-back value, one cycle after the index |

## Verification
`wr_err` is combinational, so the bench checks it shortly after it drives a write, before the clock edge. Every write and every read-back index is applied half a period before an edge. The read-back value is due after that edge, so it is checked at the following falling edge. The expected value comes from a behavioural model evaluated before it applies the same write, which also covers the read-during-write case. Pointer behaviour (reset, advance, wrap, untouched by idle or refused writes) is observed only through where later data writes land when read back.

// File: rtl/vctl_pkg.sv
package vctl_pkg;

  typedef enum logic [2:0] {
    OP_IDLE = 3'd0,
    OP_PIDX = 3'd1,
    OP_PDAT = 3'd2,
    OP_SHAD = 3'd3,
    OP_BAD  = 3'd4
  } wr_op_e;

  // register codes whose meaning other logic depends on
  localparam int PAL_DATA_CODE   = 0;
  localparam int PAL_IDX_CODE    = 1;
  localparam int SHADOW_BASE_DEF = 64;

endpackage

// File: rtl/vctl_wr_decode.sv
module vctl_wr_decode
  import vctl_pkg::*;
#(
  parameter int SEL_W       = 8,
  parameter int DATA_W      = 24,
  parameter int NUM_SHADOW  = 24,
  parameter int SHADOW_BASE = SHADOW_BASE_DEF,
  parameter int SH_IW       = $clog2(NUM_SHADOW)
) (
  input  logic                    wr_en,
  input  logic [SEL_W+DATA_W-1:0] wr_word,
  output wr_op_e                  op,
  output logic [SH_IW-1:0]        sh_idx,
  output logic [DATA_W-1:0]       data
);

  localparam int WORD_W = SEL_W + DATA_W;
  localparam logic [SEL_W:0] BASE_X = (SEL_W+1)'(SHADOW_BASE);
  localparam logic [SEL_W:0] NUM_X  = (SEL_W+1)'(NUM_SHADOW);

  logic [SEL_W-1:0] sel;
  logic [SEL_W:0]   off;
  logic             sh_hit;

  assign sel  = wr_word[WORD_W-1 -: SEL_W];
  assign data = wr_word[DATA_W-1:0];

  // an underflowing offset has its top bit set and fails the range test
  assign off    = {1'b0, sel} - BASE_X;
  assign sh_hit = (off < NUM_X);
  assign sh_idx = off[SH_IW-1:0];

  always_comb begin
    op = OP_IDLE;
    if (wr_en) begin
      if (sel == SEL_W'(PAL_DATA_CODE)) begin
        op = OP_PDAT;
      end else if (sel == SEL_W'(PAL_IDX_CODE)) begin
        op = OP_PIDX;
      end else if (sh_hit) begin
        op = OP_SHAD;
      end else begin
        op = OP_BAD;
      end
    end
  end

endmodule

// File: rtl/vctl_pal_ptr.sv
module vctl_pal_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  output logic [AW-1:0] ptr
);

  logic [AW-1:0] ptr_d;
  logic [AW-1:0] ptr_q;

  // natural modulo-2^AW wrap on advance
  always_comb begin
    ptr_d = ptr_q;
    if (clr) begin
      ptr_d = '0;
    end else if (adv) begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (clr || adv) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/vctl_pal_ram.sv
module vctl_pal_ram #(
  parameter int AW = 8,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // registered read returns the pre-write content on a collision
  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata_q <= mem[raddr];
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/vctl_shadow_file.sv
module vctl_shadow_file #(
  parameter int N   = 24,
  parameter int IW  = $clog2(N),
  parameter int RIW = 8,
  parameter int DW  = 24
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IW-1:0]        widx,
  input  logic [DW-1:0]        wdata,
  input  logic [RIW-1:0]       ridx,
  output logic [DW-1:0]        rdata,
  output logic [N-1:0][DW-1:0] flat
);

  logic [N-1:0]          row_we;
  logic [N-1:0][DW-1:0]  sh_d;
  logic [N-1:0][DW-1:0]  sh_q;
  logic [DW-1:0]         rd_d;
  logic [DW-1:0]         rd_q;

  for (genvar g = 0; g < N; g++) begin : g_row
    assign row_we[g] = we && (widx == IW'(g));
  end

  always_comb begin
    sh_d = sh_q;
    for (int i = 0; i < N; i++) begin
      if (row_we[i]) begin
        sh_d[i] = wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (we) begin
      sh_q <= sh_d;
    end
  end

  // indices past the last row read as zero
  always_comb begin
    rd_d = '0;
    for (int i = 0; i < N; i++) begin
      if (ridx == RIW'(i)) begin
        rd_d = sh_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end

  assign rdata = rd_q;
  assign flat  = sh_q;

endmodule

// File: rtl/vctl_regport.sv
module vctl_regport
  import vctl_pkg::*;
#(
  parameter int SEL_W       = 8,
  parameter int DATA_W      = 24,
  parameter int PAL_AW      = 8,
  parameter int NUM_SHADOW  = 24,
  parameter int SHADOW_BASE = SHADOW_BASE_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [SEL_W+DATA_W-1:0] wr_word,
  output logic                    wr_err,
  input  logic                    rd_space,
  input  logic [PAL_AW-1:0]       rd_idx,
  output logic [DATA_W-1:0]       rd_data
);

  localparam int SH_IW = $clog2(NUM_SHADOW);

  wr_op_e                            op;
  logic [SH_IW-1:0]                  sh_idx;
  logic [DATA_W-1:0]                 wdata;
  logic [PAL_AW-1:0]                 pal_ptr;
  logic [DATA_W-1:0]                 pal_rd;
  logic [DATA_W-1:0]                 sh_rd;
  logic [NUM_SHADOW-1:0][DATA_W-1:0] shadow_flat;
  logic                              space_d;
  logic                              space_q;

  vctl_wr_decode #(
    .SEL_W      (SEL_W),
    .DATA_W     (DATA_W),
    .NUM_SHADOW (NUM_SHADOW),
    .SHADOW_BASE(SHADOW_BASE),
    .SH_IW      (SH_IW)
  ) u_dec (
    .wr_en  (wr_en),
    .wr_word(wr_word),
    .op     (op),
    .sh_idx (sh_idx),
    .data   (wdata)
  );

  vctl_pal_ptr #(
    .AW(PAL_AW)
  ) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (op == OP_PIDX),
    .adv  (op == OP_PDAT),
    .ptr  (pal_ptr)
  );

  vctl_pal_ram #(
    .AW(PAL_AW),
    .DW(DATA_W)
  ) u_ram (
    .clk  (clk),
    .we   (op == OP_PDAT),
    .waddr(pal_ptr),
    .wdata(wdata),
    .raddr(rd_idx),
    .rdata(pal_rd)
  );

  vctl_shadow_file #(
    .N  (NUM_SHADOW),
    .IW (SH_IW),
    .RIW(PAL_AW),
    .DW (DATA_W)
  ) u_shadow (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (op == OP_SHAD),
    .widx (sh_idx),
    .wdata(wdata),
    .ridx (rd_idx),
    .rdata(sh_rd),
    .flat (shadow_flat)
  );

  // remember which space the pending read came from
  assign space_d = rd_space;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      space_q <= 1'b0;
    end else begin
      space_q <= space_d;
    end
  end

  assign rd_data = space_q ? pal_rd : sh_rd;
  assign wr_err  = (op == OP_BAD);

endmodule

// File: rtl/vctl_regport_chk.sv
module vctl_regport_chk
  import vctl_pkg::*;
#(
  parameter int SEL_W      = 8,
  parameter int DATA_W     = 24,
  parameter int PAL_AW     = 8,
  parameter int NUM_SHADOW = 24
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           wr_en,
  input logic [SEL_W-1:0]               wr_sel,
  input logic                           wr_err,
  input logic [PAL_AW-1:0]              pal_ptr,
  input logic [NUM_SHADOW*DATA_W-1:0]   shadow_flat
);

  // R6
  err_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> wr_en);

  // R6
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> ($stable(pal_ptr) && $stable(shadow_flat)));

  // R2
  idx_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(PAL_IDX_CODE)) |=> (pal_ptr == '0));

  // R3
  data_bumps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == SEL_W'(PAL_DATA_CODE))
      |=> (pal_ptr == PAL_AW'($past(pal_ptr) + 1'b1)));

  // R10
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pal_ptr) && $stable(shadow_flat)));

endmodule

bind vctl_regport vctl_regport_chk #(
  .SEL_W     (SEL_W),
  .DATA_W    (DATA_W),
  .PAL_AW    (PAL_AW),
  .NUM_SHADOW(NUM_SHADOW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_sel     (wr_word[SEL_W+DATA_W-1 -: SEL_W]),
  .wr_err     (wr_err),
  .pal_ptr    (pal_ptr),
  .shadow_flat(shadow_flat)
);

// File: tb/vctl_regport_tb.sv
module vctl_regport_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NSH = 24;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_word;
  logic        wr_err;
  logic        rd_space;
  logic [7:0]  rd_idx;
  logic [23:0] rd_data;

  int total;
  int bad;
  bit done;

  // behavioural reference state
  logic [23:0] pal_m [256];
  bit          pal_ok [256];
  logic [23:0] sh_m [NSH];
  int          ptr_m;

  vctl_regport u_dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .wr_err  (wr_err),
    .rd_space(rd_space),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  function automatic bit code_known(input logic [7:0] c);
    return (c == 8'h00) || (c == 8'h01) || (c >= 8'h40 && c < 8'h58);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // one clock: drive at falling edge, check err before the edge, rd_data after
  task automatic step(input bit wen, input logic [7:0] code, input logic [23:0] dat,
                      input bit rsp, input logic [7:0] ridx, input string tag);
    logic [23:0] exp_rd;
    bit          known;
    bit          exp_err;
    wr_en    = wen;
    wr_word  = {code, dat};
    rd_space = rsp;
    rd_idx   = ridx;
    #1;
    exp_err = wen && !code_known(code);
    check(wr_err === exp_err, exp_err ? "R6" : tag, "wr_err",
          32'(wr_err), 32'(exp_err));
    if (rsp) begin
      known  = pal_ok[ridx];
      exp_rd = pal_m[ridx];
    end else begin
      known  = 1'b1;
      exp_rd = (ridx < 8'(NSH)) ? sh_m[ridx] : 24'h0;
    end
    @(posedge clk);
    if (wen) begin
      if (code == 8'h00) begin
        pal_m[ptr_m]  = dat;
        pal_ok[ptr_m] = 1'b1;
        ptr_m         = (ptr_m + 1) % 256;
      end else if (code == 8'h01) begin
        ptr_m = 0;
      end else if (code >= 8'h40 && code < 8'h58) begin
        sh_m[code - 8'h40] = dat;
      end
    end
    @(negedge clk);
    if (known) begin
      check(rd_data === exp_rd, tag, "rd_data", 32'(rd_data), 32'(exp_rd));
    end
  endtask

  task automatic rd_pal(input int idx, input string tag);
    step(1'b0, 8'h00, 24'h0, 1'b1, 8'(idx), tag);
  endtask

  task automatic rd_sh(input int idx, input string tag);
    step(1'b0, 8'h00, 24'h0, 1'b0, 8'(idx), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    total = 0;
    bad = 0;
    done = 1'b0;
    ptr_m = 0;
    for (int i = 0; i < 256; i++) begin
      pal_ok[i] = 1'b0;
      pal_m[i]  = 24'h0;
    end
    for (int i = 0; i < NSH; i++) sh_m[i] = 24'h0;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_word = 32'h0;
    rd_space = 1'b0;
    rd_idx = 8'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    check(rd_data === 24'h0, "R8", "rd_data in reset", 32'(rd_data), 32'h0);
    rst_n = 1'b1;
    for (int i = 0; i < NSH; i++) rd_sh(i, "R8");

    // R5 every shadow register, read back through R7
    for (int i = 0; i < NSH; i++)
      step(1'b1, 8'(8'h40 + i), 24'(24'h100 * (i + 1) + 24'h0A5), 1'b0, 8'h0, "R5");
    for (int i = 0; i < NSH; i++) rd_sh(i, "R5");
    rd_sh(24, "R7");
    rd_sh(200, "R7");
    rd_sh(255, "R7");

    // R3 consecutive colour writes
    step(1'b1, 8'h01, 24'h0, 1'b0, 8'h0, "R2");
    for (int i = 0; i < 6; i++)
      step(1'b1, 8'h00, 24'(24'h0F0000 + i * 24'h011), 1'b0, 8'h0, "R3");
    for (int i = 0; i < 6; i++) rd_pal(i, "R3");

    // R2 pointer reset ignores its value bits and leaves entries alone
    step(1'b1, 8'h01, 24'hFFFFFF, 1'b0, 8'h0, "R2");
    for (int i = 0; i < 6; i++) rd_pal(i, "R2");
    step(1'b1, 8'h00, 24'h123456, 1'b0, 8'h0, "R2");
    rd_pal(0, "R2");
    rd_pal(1, "R2");

    // R10 idle cycles with a data code on the bus
    step(1'b0, 8'h00, 24'hABCDEF, 1'b1, 8'h1, "R10");
    step(1'b0, 8'h45, 24'hABCDEF, 1'b0, 8'h5, "R10");
    step(1'b1, 8'h00, 24'h777777, 1'b0, 8'h0, "R10");
    rd_pal(1, "R10");
    rd_sh(5, "R10");

    // R6 refused codes
    step(1'b1, 8'h02, 24'h111111, 1'b0, 8'h0, "R6");
    step(1'b1, 8'h3F, 24'h222222, 1'b1, 8'h2, "R6");
    step(1'b1, 8'h58, 24'h333333, 1'b0, 8'h17, "R6");
    step(1'b1, 8'hFF, 24'h444444, 1'b0, 8'h0, "R6");
    step(1'b1, 8'h80, 24'h555555, 1'b1, 8'h2, "R6");
    step(1'b1, 8'h00, 24'h0BEEF0, 1'b0, 8'h0, "R6");
    rd_pal(2, "R6");
    for (int i = 0; i < NSH; i++) rd_sh(i, "R6");

    // R4 wrap: 257 writes after a pointer reset
    step(1'b1, 8'h01, 24'h0, 1'b0, 8'h0, "R4");
    for (int i = 0; i < 257; i++)
      step(1'b1, 8'h00, 24'(24'h400000 + i), 1'b0, 8'h0, "R4");
    rd_pal(0, "R4");
    rd_pal(1, "R4");
    rd_pal(255, "R4");
    step(1'b1, 8'h00, 24'h5A5A5A, 1'b0, 8'h0, "R4");
    rd_pal(1, "R4");

    // R9 read and write the same location in one cycle
    step(1'b1, 8'h00, 24'h999999, 1'b1, 8'h2, "R9");
    rd_pal(2, "R9");
    step(1'b1, 8'h47, 24'h888888, 1'b0, 8'h7, "R9");
    rd_sh(7, "R9");

    // R1 mixed traffic against the model
    for (int n = 0; n < 3000; n++) begin
      int          pick;
      logic [7:0]  c;
      pick = $urandom_range(0, 9);
      case (pick)
        0:       c = 8'h01;
        1, 2, 3: c = 8'h00;
        4, 5, 6: c = 8'(8'h40 + $urandom_range(0, NSH - 1));
        7:       c = 8'(8'h02 + $urandom_range(0, 8'h3D));
        default: c = 8'(8'h58 + $urandom_range(0, 8'hA7));
      endcase
      step(1'($urandom_range(0, 3) != 0), c, 24'($urandom),
           1'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), "R1");
    end

    finish_run();
  end

endmodule